// File: doc/BRIEF.md
# Two-Channel Start-Window Coincidence Detector

This block pairs pulses from two detector channels. Each channel arrives as a gate from its own threshold discriminator, which is high while that channel's pulse sits above its hysteresis thresholds. Each channel also has a flag that goes high when the pulse is too large. A pair counts only when both gates rise within a programmable number of clock cycles of each other. A common setting is 15 cycles, which is 120 ns at an 8 ns clock.

After a pair is matched, the block watches both channels until the first gate falls. If either over-threshold flag is high in that interval, the pair is rejected and a one-cycle discard strobe is raised for diagnostics. If no flag rises, a one-cycle coincidence pulse is raised. In both cases the block then waits until both gates are low before it looks for a new pair. This way a long pulse cannot be counted twice.

Top module: `coinc_detector`

## Requirements
- R1: While rst_ni is low, and after reset until a pair is matched, coinc_o and discard_o are low.
- R2: Gates that rise in the same cycle form a match with zero separation.
- R3: When the second gate rises k cycles after the first, with 1 <= k <= window_i, the pair is matched. Either channel may rise first.
- R4: When the second gate has not risen by k = window_i, the open window closes and the block hunts again. A rise at k = window_i + 1 therefore yields no event.
- R5: For a matched pair with no over-threshold flag, coinc_o is high for exactly one cycle. That cycle is the one registered from the first sampled cycle in which either gate is low.
- R6: An over-threshold flag that is high in any cycle after the match, up to and including the cycle in which the first gate is low, raises discard_o for one cycle and no coinc_o. When the flag and the gate drop come in the same cycle, the discard wins.
- R7: An over-threshold flag that is already high in the match cycle gives an immediate discard, registered from that cycle.
- R8: After an emit or a discard, gate rises are ignored until both gates have been low together.
- R9: With window_i = 0, only same-cycle rises match.
- R10: Over-threshold flags that fall before the match have no effect.
- R11: coinc_o and discard_o are never high together, and each is high for at most one cycle in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_a_i | input | 1 | Discriminator gate, channel A |
| gate_b_i | input | 1 | Discriminator gate, channel B |
| over_a_i | input | 1 | Over-threshold flag, channel A |
| over_b_i | input | 1 | Over-threshold flag, channel B |
| window_i | input | WIN_W (8) | Largest allowed start separation, in cycles |
| coinc_o | output | 1 | One-cycle pulse for an accepted coincidence |
| discard_o | output | 1 | One-cycle pulse for a vetoed coincidence |

## Verification
The veto check and the end-of-pulse check can fall in the same cycle. This happens when an over-threshold flag goes high in the very cycle in which the first gate is seen low. The bench drives the flag on channel B in the same cycle that gate A falls, and expects exactly one discard strobe in that cycle and no coincidence pulse. A second collision puts the match and the veto in one cycle: the flag is already high when the second gate rises. The bench judges it the same way, with the discard registered from the match cycle.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  localparam int unsigned NCH = 2;
  localparam int unsigned DEF_WIN_W = 8;
  localparam int unsigned DEF_WINDOW = 15;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_REARM = 2'd2
  } coinc_st_e;
endpackage

// File: rtl/coinc_edge.sv
module coinc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/coinc_window.sv
module coinc_window #(
  parameter int unsigned WIN_W = coinc_pkg::DEF_WIN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_a_i,
  input  logic             rise_b_i,
  input  logic [WIN_W-1:0] window_i,
  output logic             match_o
);
  logic             open_q;
  logic             first_a_q;
  logic [WIN_W-1:0] cnt_q;
  logic             rise_other;
  logic             late_match;
  logic             timeout;
  logic             start;

  // rise of the channel that did not open the window
  assign rise_other = first_a_q ? rise_b_i : rise_a_i;
  assign late_match = open_q & rise_other & (cnt_q <= window_i);
  assign match_o    = en_i & ((rise_a_i & rise_b_i) | late_match);
  assign timeout    = open_q & ~late_match & (cnt_q >= window_i);
  assign start      = en_i & ~open_q & (rise_a_i ^ rise_b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      first_a_q <= 1'b0;
      cnt_q     <= '0;
    end else if (!en_i || match_o || timeout) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      open_q    <= 1'b1;
      first_a_q <= rise_a_i;
      cnt_q     <= WIN_W'(1);
    end else if (open_q) begin
      cnt_q <= cnt_q + WIN_W'(1);
    end
  end

  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> cnt_q != '0); // R4

  AST_ZERO_WIN_NO_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (window_i == '0 && open_q) |-> !match_o); // R9
endmodule

// File: rtl/coinc_fsm.sv
module coinc_fsm
  import coinc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      match_i,
  input  logic      gate_a_i,
  input  logic      gate_b_i,
  input  logic      over_a_i,
  input  logic      over_b_i,
  output logic      hunt_o,
  output coinc_st_e st_o,
  output logic      coinc_o,
  output logic      discard_o
);
  coinc_st_e st_q, st_d;
  logic      coinc_d, discard_d;
  logic      over_any, gate_low, judge;

  assign over_any = over_a_i | over_b_i;
  assign gate_low = ~gate_a_i | ~gate_b_i;
  // judge the pair in the match cycle and every armed cycle
  assign judge    = (st_q == ST_HUNT && match_i) || (st_q == ST_ARMED);

  always_comb begin
    st_d      = st_q;
    coinc_d   = 1'b0;
    discard_d = 1'b0;
    if (judge) begin
      if (over_any) begin
        discard_d = 1'b1;
        st_d      = ST_REARM;
      end else if (gate_low) begin
        coinc_d = 1'b1;
        st_d    = ST_REARM;
      end else begin
        st_d = ST_ARMED;
      end
    end else if (st_q == ST_REARM && !gate_a_i && !gate_b_i) begin
      st_d = ST_HUNT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_HUNT;
      coinc_o   <= 1'b0;
      discard_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      coinc_o   <= coinc_d;
      discard_o <= discard_d;
    end
  end

  assign hunt_o = (st_q == ST_HUNT);
  assign st_o   = st_q;

  AST_NO_EMIT_ON_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && (over_a_i || over_b_i)) |=> (discard_o && !coinc_o)); // R6

  AST_REARM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REARM && (gate_a_i || gate_b_i)) |=> (st_q == ST_REARM)); // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coinc_o || discard_o) |=> !(coinc_o || discard_o)); // R11

  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(coinc_o && discard_o)); // R11
endmodule

// File: rtl/coinc_detector.sv
module coinc_detector
  import coinc_pkg::*;
#(
  parameter int unsigned WIN_W = DEF_WIN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_a_i,
  input  logic             gate_b_i,
  input  logic             over_a_i,
  input  logic             over_b_i,
  input  logic [WIN_W-1:0] window_i,
  output logic             coinc_o,
  output logic             discard_o
);
  logic [NCH-1:0] gate;
  logic [NCH-1:0] rise;
  logic           hunt;
  logic           match;
  coinc_st_e      st;

  assign gate = {gate_b_i, gate_a_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    coinc_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .gate_i (gate[c]),
      .rise_o (rise[c])
    );
  end

  coinc_window #(.WIN_W(WIN_W)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (hunt),
    .rise_a_i (rise[0]),
    .rise_b_i (rise[1]),
    .window_i (window_i),
    .match_o  (match)
  );

  coinc_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .match_i   (match),
    .gate_a_i  (gate_a_i),
    .gate_b_i  (gate_b_i),
    .over_a_i  (over_a_i),
    .over_b_i  (over_b_i),
    .hunt_o    (hunt),
    .st_o      (st),
    .coinc_o   (coinc_o),
    .discard_o (discard_o)
  );

  AST_SAME_CYCLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_HUNT && rise[0] && rise[1]) |=> (st != ST_HUNT || coinc_o || discard_o)); // R2

  AST_VETO_AT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && (over_a_i || over_b_i)) |=> discard_o); // R7
endmodule

// File: tb/coinc_detector_tb_top.sv
module coinc_detector_tb_top;
  localparam int WIN_W = 8;
  localparam int NCYC  = 40;
  localparam int NVEC  = 14;

  typedef struct packed {
    int a_st; int a_len; int b_st; int b_len; int b2_st; int b2_len;
    int ov_mask; int ov_st; int ov_len; int win;
    int kind;  // 0 none, 1 coinc, 2 discard
    int cyc;   // cycle whose inputs produce the pulse
    int req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{2, 8, 2, 8, 0, 0, 0, 0, 0, 15, 1, 10, 2},   // R2 same-cycle rise
    '{2, 20, 17, 10, 0, 0, 0, 0, 0, 15, 1, 22, 3}, // R3 k = window
    '{2, 20, 18, 10, 0, 0, 0, 0, 0, 15, 0, 0, 4},  // R4 k = window+1
    '{6, 10, 3, 8, 0, 0, 0, 0, 0, 4, 1, 11, 3},    // R3 B first
    '{2, 5, 3, 5, 0, 0, 0, 0, 0, 0, 0, 0, 9},      // R9 zero window, k=1
    '{4, 6, 4, 3, 0, 0, 0, 0, 0, 0, 1, 7, 9},      // R9 zero window, same cycle
    '{2, 10, 4, 10, 0, 0, 1, 8, 1, 15, 2, 8, 6},   // R6 over A while armed
    '{2, 10, 3, 12, 0, 0, 2, 12, 1, 15, 2, 12, 6}, // R6 over with gate drop
    '{2, 6, 3, 6, 0, 0, 2, 1, 4, 15, 2, 3, 7},     // R7 over high at match
    '{2, 10, 5, 10, 0, 0, 1, 3, 1, 15, 1, 12, 10}, // R10 over before match
    '{2, 18, 2, 3, 8, 4, 0, 0, 0, 15, 1, 5, 8},    // R8 rise ignored in rearm
    '{3, 6, 5, 8, 0, 0, 2, 6, 2, 2, 2, 6, 6},      // R6 over B while armed
    '{2, 5, 3, 2, 0, 0, 0, 0, 0, 1, 1, 5, 5},      // R5 first drop on B
    '{2, 8, 2, 8, 0, 0, 0, 0, 0, 15, 1, 10, 11}    // R11 re-arm, single pulse
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             gate_a = 1'b0, gate_b = 1'b0, over_a = 1'b0, over_b = 1'b0;
  logic [WIN_W-1:0] window = 8'd15;
  logic             coinc, discard;
  int               n_chk = 0, n_fail = 0, cyc_cnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  coinc_detector #(.WIN_W(WIN_W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .gate_a_i  (gate_a),
    .gate_b_i  (gate_b),
    .over_a_i  (over_a),
    .over_b_i  (over_b),
    .window_i  (window),
    .coinc_o   (coinc),
    .discard_o (discard)
  );

  task automatic chk(input bit ok, input int req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int nc = 0, nd = 0, cc = -1, dc = -1;
    window = WIN_W'(v.win);
    for (int i = 0; i <= NCYC; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (coinc)   begin nc++; cc = i - 1; end
        if (discard) begin nd++; dc = i - 1; end
      end
      gate_a = (i >= v.a_st && i < v.a_st + v.a_len);
      gate_b = (i >= v.b_st && i < v.b_st + v.b_len) ||
               (v.b2_len > 0 && i >= v.b2_st && i < v.b2_st + v.b2_len);
      over_a = v.ov_mask[0] && i >= v.ov_st && i < v.ov_st + v.ov_len;
      over_b = v.ov_mask[1] && i >= v.ov_st && i < v.ov_st + v.ov_len;
    end
    gate_a = 0; gate_b = 0; over_a = 0; over_b = 0;
    chk(nc == (v.kind == 1 ? 1 : 0) && (v.kind != 1 || cc == v.cyc), v.req,
        "coinc pulse count*100+cycle", nc * 100 + cc,
        (v.kind == 1) ? 100 + v.cyc : -1);
    chk(nd == (v.kind == 2 ? 1 : 0) && (v.kind != 2 || dc == v.cyc), v.req,
        "discard pulse count*100+cycle", nd * 100 + dc,
        (v.kind == 2) ? 200 + v.cyc - 100 : -1);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired: actual %0d expected <= 20000", cyc_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: outputs low in reset, even with gates toggling
    gate_a = 1; gate_b = 1;
    repeat (3) @(negedge clk);
    chk(!coinc && !discard, 1, "outputs during reset", {coinc, discard}, 0);
    gate_a = 0; gate_b = 0;
    @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    chk(!coinc && !discard, 1, "outputs after reset", {coinc, discard}, 0);

    for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

    // R1: reset in the middle of an armed pair drops it
    window = 8'd15;
    @(negedge clk); gate_a = 1; gate_b = 1;
    repeat (3) @(negedge clk);
    rst_ni = 0; gate_a = 0; gate_b = 0;
    repeat (2) @(negedge clk);
    chk(!coinc && !discard, 1, "outputs in mid-pair reset", {coinc, discard}, 0);
    rst_ni = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (coinc || discard) seen++;
      end
      chk(seen == 0, 1, "pulses after mid-pair reset", seen, 0);
    end

    // R4: after a timeout a fresh pair still matches
    run_vec(VEC[2]);
    run_vec(VEC[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule